// File: doc/BRIEF.md
# Subgraph Isomorphism Search Engine

This block decides whether a small pattern graph fits into a larger target graph. Each graph is undirected and has up to 15 vertices. Pattern vertex `i` must be assigned to a distinct target vertex so that every pattern edge lands on a target edge. The target may have extra edges, so the embedding is not required to be induced. Both adjacency matrices are loaded row by row through a write port while the engine is idle. A start pulse then launches a depth-first search.

The search assigns one pattern vertex per level and tries target candidates in ascending order. Once a candidate is free, it is tested against each vertex already mapped, one comparison per clock, by looking up the target adjacency row of the candidate. Unmapped vertices play no part in that test. A failed test or an already used candidate moves to the next candidate. When a level runs out of candidates, the search returns to the level above and frees the vertex held there.

The engine stops at the first complete mapping, or when the first level has no candidates left. It then reports done, a found flag, the mapping and the number of cycles the search took.

Top module: `subiso_engine`

## Requirements
- R1: After reset, busy, done and found are low and cycleCount is zero.
- R2: When wrEn is high while idle, wrData is stored as adjacency row wrRow of the target graph (wrTarget=1) or of the pattern graph (wrTarget=0). Bit j of the row is the edge between vertex wrRow and vertex j.
- R3: A start pulse while idle clears done and found, and busy is high from the next cycle on.
- R4: If an injective, edge-preserving assignment exists, the search ends with done=1 and found=1. mapFlat[4i+3:4i] then gives the target vertex of pattern vertex i, and every pattern edge among vertices below patSize maps onto a target edge.
- R5: The reported mapping is one-to-one: no two pattern vertices share a target vertex.
- R6: If no such assignment exists, the search ends with done=1 and found=0.
- R7: Matrix entries in rows or columns at or above patSize (pattern) or tgtSize (target) have no effect on found or on the mapping.
- R8: cycleCount equals the number of cycles busy was high during the last search. done rises in the same cycle busy falls, and done and busy are never high together.
- R9: The reported mapping is the first one found by a depth-first search that tries target candidates in ascending order at each level, with pattern vertex 0 at the first level.
- R10: A pattern larger than the target (patSize > tgtSize) ends with found=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Adjacency row write strobe |
| wrTarget | input | 1 | 1 selects the target matrix, 0 the pattern matrix |
| wrRow | input | 4 | Row (vertex) being written |
| wrData | input | 15 | Row contents, bit j is the edge to vertex j |
| patSize | input | 4 | Pattern vertex count, 1 to 15, sampled at start |
| tgtSize | input | 4 | Target vertex count, sampled at start |
| start | input | 1 | Start pulse, honoured while idle |
| busy | output | 1 | Search in progress |
| done | output | 1 | Search finished, held until the next start |
| found | output | 1 | A mapping was found |
| mapFlat | output | 60 | Target vertex per pattern vertex, 4 bits each |
| cycleCount | output | 32 | Busy cycles of the last search |

## Verification
busy is due at the first falling edge after the edge that samples start, and the bench checks busy high and done low there. The search length depends on the data, so the bench does not predict a fixed latency. Instead it counts busy at every falling edge until done appears, and compares that count with cycleCount in the same sample where done rises and busy falls. found and the mapping are read in that sample too. They are compared with a depth-first reference that the bench runs on its own copy of the graphs, and the mapping is also checked for edge preservation and distinct targets.

// File: rtl/sgi_pkg.sv
package sgi_pkg;
  // strobes from the sequencer to the datapath
  typedef struct packed {
    logic init;       // latch sizes, clear search state
    logic candNext;   // advance candidate at current level
    logic checkBegin; // reset comparison index
    logic kStep;      // advance comparison index
    logic accept;     // claim candidate and descend
    logic retreat;    // release parent and move to its next candidate
    logic finish;     // search over
    logic hit;        // with finish: mapping complete
  } sgi_strobe_t;

  // status from the datapath to the sequencer
  typedef struct packed {
    logic candOver;
    logic candUsed;
    logic atRoot;
    logic lastK;
    logic edgeBad;
    logic lastLevel;
  } sgi_status_t;
endpackage

// File: rtl/sgi_ctrl.sv
module sgi_ctrl
  import sgi_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        start,
  input  sgi_status_t stat,
  output sgi_strobe_t strb,
  output logic        busy
);
  typedef enum logic [1:0] {S_IDLE, S_TRY, S_CHECK} state_t;
  state_t state, stateNxt;

  always_ff @(posedge clk) begin
    if (!rstN) state <= S_IDLE;
    else       state <= stateNxt;
  end

  assign busy = (state != S_IDLE);

  always_comb begin
    strb     = '0;
    stateNxt = state;
    unique case (state)
      S_IDLE: if (start) begin
        strb.init = 1'b1;
        stateNxt  = S_TRY;
      end
      S_TRY: begin
        if (stat.candOver) begin
          if (stat.atRoot) begin
            strb.finish = 1'b1;
            stateNxt    = S_IDLE;
          end else begin
            strb.retreat = 1'b1;
          end
        end else if (stat.candUsed) begin
          strb.candNext = 1'b1;
        end else if (stat.atRoot) begin
          if (stat.lastLevel) begin
            strb.finish = 1'b1;
            strb.hit    = 1'b1;
            stateNxt    = S_IDLE;
          end else begin
            strb.accept = 1'b1;
          end
        end else begin
          strb.checkBegin = 1'b1;
          stateNxt        = S_CHECK;
        end
      end
      S_CHECK: begin
        if (stat.edgeBad) begin
          strb.candNext = 1'b1;
          stateNxt      = S_TRY;
        end else if (stat.lastK) begin
          if (stat.lastLevel) begin
            strb.finish = 1'b1;
            strb.hit    = 1'b1;
            stateNxt    = S_IDLE;
          end else begin
            strb.accept = 1'b1;
            stateNxt    = S_TRY;
          end
        end else begin
          strb.kStep = 1'b1;
        end
      end
      default: stateNxt = S_IDLE;
    endcase
  end

  // R3: an accepted start makes the engine busy on the next cycle
  assert_start_busy_R3: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && start) |=> busy);

  // R6: the sequencer never retreats from the first level
  assert_no_root_retreat_R6: assert property (@(posedge clk) disable iff (!rstN)
    strb.retreat |-> !stat.atRoot);
endmodule

// File: rtl/sgi_datapath.sv
module sgi_datapath
  import sgi_pkg::*;
#(
  parameter int unsigned MAX_V = 15,
  parameter int unsigned CNT_W = 32,
  localparam int unsigned IDX_W = $clog2(MAX_V + 1)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               wrEn,
  input  logic               wrTarget,
  input  logic [IDX_W-1:0]   wrRow,
  input  logic [MAX_V-1:0]   wrData,
  input  logic [IDX_W-1:0]   patSize,
  input  logic [IDX_W-1:0]   tgtSize,
  input  sgi_strobe_t        strb,
  input  logic               busy,
  output sgi_status_t        stat,
  output logic               done,
  output logic               found,
  output logic [MAX_V*IDX_W-1:0] mapFlat,
  output logic [CNT_W-1:0]   cycleCount
);
  logic [MAX_V-1:0] patMem [MAX_V];
  logic [MAX_V-1:0] tgtMem [MAX_V];
  logic [IDX_W-1:0] mapReg [MAX_V];
  logic [MAX_V-1:0] used;
  logic [IDX_W-1:0] level, kIdx, patSz, tgtSz;

  // adjacency row memories
  always_ff @(posedge clk) begin
    if (wrEn && !busy && (wrRow < IDX_W'(MAX_V))) begin
      if (wrTarget) tgtMem[wrRow] <= wrData;
      else          patMem[wrRow] <= wrData;
    end
  end

  logic [IDX_W-1:0] cand, parent, mappedK;
  logic [MAX_V-1:0] patRow, tgtRow;
  assign cand    = mapReg[level];
  assign parent  = mapReg[level - 1'b1];
  assign mappedK = mapReg[kIdx];
  assign patRow  = patMem[level];
  assign tgtRow  = tgtMem[cand];

  always_comb begin
    stat.candOver  = (cand >= tgtSz);
    stat.candUsed  = (cand < IDX_W'(MAX_V)) ? used[cand] : 1'b1;
    stat.atRoot    = (level == '0);
    stat.lastK     = ({1'b0, kIdx} + 1'b1) == {1'b0, level};
    stat.edgeBad   = patRow[kIdx] && !tgtRow[mappedK];
    stat.lastLevel = ({1'b0, level} + 1'b1) >= {1'b0, patSz};
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      level <= '0;
      kIdx  <= '0;
      patSz <= '0;
      tgtSz <= '0;
      used  <= '0;
      done  <= 1'b0;
      found <= 1'b0;
      for (int v = 0; v < MAX_V; v++) mapReg[v] <= '0;
    end else begin
      if (strb.init) begin
        level     <= '0;
        used      <= '0;
        done      <= 1'b0;
        found     <= 1'b0;
        patSz     <= patSize;
        tgtSz     <= tgtSize;
        mapReg[0] <= '0;
      end
      if (strb.candNext)   mapReg[level] <= cand + 1'b1;
      if (strb.checkBegin) kIdx <= '0;
      if (strb.kStep)      kIdx <= kIdx + 1'b1;
      if (strb.accept) begin
        used[cand] <= 1'b1;
        level      <= level + 1'b1;
        for (int v = 0; v < MAX_V; v++)
          if (IDX_W'(v) == level + 1'b1) mapReg[v] <= '0;
      end
      if (strb.retreat) begin
        used[parent]          <= 1'b0;
        mapReg[level - 1'b1]  <= parent + 1'b1;
        level                 <= level - 1'b1;
      end
      if (strb.finish) begin
        done  <= 1'b1;
        found <= strb.hit;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)          cycleCount <= '0;
    else if (strb.init) cycleCount <= '0;
    else if (busy)      cycleCount <= cycleCount + 1'b1;
  end

  for (genvar g = 0; g < MAX_V; g++) begin : g_map
    assign mapFlat[g*IDX_W +: IDX_W] = mapReg[g];
  end

  // R5: a candidate is only claimed when no earlier level holds it
  assert_inject_R5: assert property (@(posedge clk) disable iff (!rstN)
    strb.accept |-> !used[cand]);

  // R8: done and busy are exclusive
  assert_done_idle_R8: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busy);

  // R8: counter advances once per busy cycle
  assert_count_step_R8: assert property (@(posedge clk) disable iff (!rstN)
    busy |=> cycleCount == $past(cycleCount) + 1'b1);

  // R4: found is only reported with done
  assert_found_done_R4: assert property (@(posedge clk) disable iff (!rstN)
    found |-> done);

  // R4: descending never passes the last pattern vertex
  assert_level_bound_R4: assert property (@(posedge clk) disable iff (!rstN)
    strb.accept |-> ({1'b0, level} + 2'd2) <= {1'b0, patSz});
endmodule

// File: rtl/subiso_engine.sv
module subiso_engine
  import sgi_pkg::*;
#(
  parameter int unsigned MAX_V = 15,
  parameter int unsigned CNT_W = 32,
  localparam int unsigned IDX_W = $clog2(MAX_V + 1)
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   wrEn,
  input  logic                   wrTarget,
  input  logic [IDX_W-1:0]       wrRow,
  input  logic [MAX_V-1:0]       wrData,
  input  logic [IDX_W-1:0]       patSize,
  input  logic [IDX_W-1:0]       tgtSize,
  input  logic                   start,
  output logic                   busy,
  output logic                   done,
  output logic                   found,
  output logic [MAX_V*IDX_W-1:0] mapFlat,
  output logic [CNT_W-1:0]       cycleCount
);
  sgi_strobe_t strb;
  sgi_status_t stat;

  sgi_ctrl u_ctrl (
    .clk   (clk),
    .rstN  (rstN),
    .start (start),
    .stat  (stat),
    .strb  (strb),
    .busy  (busy)
  );

  sgi_datapath #(.MAX_V(MAX_V), .CNT_W(CNT_W)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .wrEn       (wrEn),
    .wrTarget   (wrTarget),
    .wrRow      (wrRow),
    .wrData     (wrData),
    .patSize    (patSize),
    .tgtSize    (tgtSize),
    .strb       (strb),
    .busy       (busy),
    .stat       (stat),
    .done       (done),
    .found      (found),
    .mapFlat    (mapFlat),
    .cycleCount (cycleCount)
  );
endmodule

// File: tb/subiso_engine_bench.sv
module subiso_engine_bench;
  localparam int MV = 15;
  localparam int IW = 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic wrEn = 1'b0, wrTarget = 1'b0, start = 1'b0;
  logic [IW-1:0] wrRow = '0, patSize = '0, tgtSize = '0;
  logic [MV-1:0] wrData = '0;
  logic busy, done, found;
  logic [MV*IW-1:0] mapFlat;
  logic [31:0] cycleCount;

  always #2 clk = ~clk;

  subiso_engine u_subiso_engine (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrTarget(wrTarget), .wrRow(wrRow),
    .wrData(wrData), .patSize(patSize), .tgtSize(tgtSize), .start(start),
    .busy(busy), .done(done), .found(found), .mapFlat(mapFlat),
    .cycleCount(cycleCount)
  );

  int nChecks = 0, nFails = 0;
  int totalCycles = 0;
  logic [MV-1:0] pa [MV];
  logic [MV-1:0] ta [MV];
  int refMap [MV];
  logic refFound;
  int np, nt;
  logic [31:0] rng = 32'h1234_5678;

  always @(posedge clk) begin
    totalCycles++;
    if (totalCycles == 190000) begin
      nFails++; nChecks++;
      $display("FAIL watchdog: run hung, actual cycles %0d expected < 190000", totalCycles);
      $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
      $finish;
    end
  end

  task automatic check(input string req, input longint act, input longint exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int nextRand();
    rng = rng ^ (rng << 13);
    rng = rng ^ (rng >> 17);
    rng = rng ^ (rng << 5);
    return int'(rng & 32'h7fff_ffff);
  endfunction

  task automatic clearGraphs();
    for (int r = 0; r < MV; r++) begin pa[r] = '0; ta[r] = '0; end
  endtask

  task automatic edgeP(input int a, input int b); pa[a][b] = 1'b1; pa[b][a] = 1'b1; endtask
  task automatic edgeT(input int a, input int b); ta[a][b] = 1'b1; ta[b][a] = 1'b1; endtask

  // R2: write every row of both matrices through the port
  task automatic loadGraphs();
    for (int r = 0; r < MV; r++) begin
      @(negedge clk);
      wrEn = 1'b1; wrTarget = 1'b0; wrRow = IW'(r); wrData = pa[r];
      @(negedge clk);
      wrTarget = 1'b1; wrData = ta[r];
    end
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  // reference depth-first search, ascending candidates, first match wins
  task automatic refSearch();
    int m [MV];
    int lvl;
    logic ok;
    refFound = 1'b0;
    for (int v = 0; v < MV; v++) begin m[v] = 0; refMap[v] = 0; end
    lvl = 0;
    forever begin
      if (m[lvl] >= nt) begin
        if (lvl == 0) return;
        lvl--; m[lvl]++;
        continue;
      end
      ok = 1'b1;
      for (int k = 0; k < lvl; k++) begin
        if (m[k] == m[lvl]) ok = 1'b0;
        if (pa[lvl][k] && !ta[m[lvl]][m[k]]) ok = 1'b0;
      end
      if (ok) begin
        if (lvl == np - 1) begin
          refFound = 1'b1;
          for (int v = 0; v < MV; v++) refMap[v] = m[v];
          return;
        end
        lvl++; m[lvl] = 0;
      end else begin
        m[lvl]++;
      end
    end
  endtask

  function automatic int dutMap(input int i);
    return int'(mapFlat[i*IW +: IW]);
  endfunction

  // start a search and check all its results
  task automatic runCase(input string name, input int p, input int t);
    int busyCnt, guard;
    logic okEdges, okDistinct;
    np = p; nt = t;
    refSearch();
    @(negedge clk);
    patSize = IW'(p); tgtSize = IW'(t); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check({name, " R3 busy after start"}, busy, 1);
    check({name, " R3 done cleared"}, done, 0);
    busyCnt = 1; guard = 0;
    while (!done && guard < 60000) begin
      @(negedge clk);
      if (busy) busyCnt++;
      guard++;
    end
    check({name, " R8 search ended"}, done, 1);
    check({name, " R8 busy low with done"}, busy, 0);
    check({name, " R8 cycle count"}, cycleCount, busyCnt);
    check({name, " R4/R6 found flag"}, found, refFound);
    if (refFound && found) begin
      okEdges = 1'b1; okDistinct = 1'b1;
      for (int i = 0; i < p; i++) begin
        for (int k = 0; k < i; k++) begin
          if (dutMap(i) == dutMap(k)) okDistinct = 1'b0;
          if (pa[i][k] && !ta[dutMap(i)][dutMap(k)]) okEdges = 1'b0;
        end
        check({name, " R9 mapping entry"}, dutMap(i), refMap[i]);
      end
      check({name, " R4 edges preserved"}, okEdges, 1);
      check({name, " R5 distinct targets"}, okDistinct, 1);
    end
  endtask

  task automatic testReset();
    check("R1 busy at reset", busy, 0);
    check("R1 done at reset", done, 0);
    check("R1 found at reset", found, 0);
    check("R1 cycleCount at reset", cycleCount, 0);
  endtask

  task automatic testTriangleInK4();
    clearGraphs();
    edgeP(0,1); edgeP(1,2); edgeP(0,2);
    for (int a = 0; a < 4; a++) for (int b = a + 1; b < 4; b++) edgeT(a, b);
    loadGraphs();
    runCase("triangle in K4", 3, 4);
    check("R4 expects found", found, 1);
  endtask

  task automatic testTriangleInSquare();
    clearGraphs();
    edgeP(0,1); edgeP(1,2); edgeP(0,2);
    edgeT(0,1); edgeT(1,2); edgeT(2,3); edgeT(3,0);
    loadGraphs();
    runCase("triangle in square", 3, 4);
    check("R6 expects not found", found, 0);
  endtask

  task automatic testBacktrack();
    clearGraphs();
    edgeP(0,1); edgeP(1,2); edgeP(2,3);
    edgeT(0,4); edgeT(4,2); edgeT(2,5); edgeT(5,1); edgeT(3,1);
    loadGraphs();
    runCase("path with backtrack", 4, 6);
    check("R9 expects found", found, 1);
  endtask

  // R7: junk beyond the sizes must not change the outcome
  task automatic testJunkIgnored();
    clearGraphs();
    edgeP(0,1); edgeP(1,2); edgeP(0,2);
    edgeT(0,1); edgeT(1,2);
    for (int r = 0; r < MV; r++) begin
      for (int c = 0; c < MV; c++) begin
        if (r >= 3 || c >= 3) begin pa[r][c] = 1'b1; ta[r][c] = 1'b1; end
      end
    end
    loadGraphs();
    runCase("R7 junk outside sizes", 3, 3);
    check("R7 triangle not in path despite junk", found, 0);
    clearGraphs();
    edgeP(0,1);
    for (int r = 0; r < MV; r++) for (int c = 0; c < MV; c++)
      if (r >= 2 || c >= 2) pa[r][c] = 1'b1;
    edgeT(1,2);
    loadGraphs();
    runCase("R7 pattern junk", 2, 3);
    check("R7 single edge found", found, 1);
  endtask

  task automatic testTooLarge();
    clearGraphs();
    for (int a = 0; a < MV; a++) for (int b = a + 1; b < MV; b++) edgeT(a, b);
    loadGraphs();
    runCase("R10 pattern larger", 5, 4);
    check("R10 not found", found, 0);
  endtask

  task automatic testRandom();
    for (int trial = 0; trial < 12; trial++) begin
      int p, t;
      clearGraphs();
      p = 3 + (nextRand() % 3);
      t = 5 + (nextRand() % 4);
      for (int a = 0; a < MV; a++) for (int b = a + 1; b < MV; b++) begin
        if ((nextRand() % 100) < 45) edgeP(a, b);
        if ((nextRand() % 100) < 50) edgeT(a, b);
      end
      loadGraphs();
      runCase($sformatf("random %0d R4 R9", trial), p, t);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    testReset();
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testTriangleInK4();
    testTriangleInSquare();
    testBacktrack();
    testJunkIgnored();
    testTooLarge();
    testRandom();
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end
endmodule